// File: doc/BRIEF.md
# Destination Subnet Pass-Through Hop

This block is the switching element at an intermediate node of a network in which every destination owns a private subnet. Each packet on the subnet already has the same end-point, so the hop computes no route, keeps no flow state and computes no priority. It only picks, packet by packet, between two sources: the subnet channel arriving from upstream and the node's local injection port. The chosen flits go out on one downstream channel.

Forwarding is virtual cut-through. A packet is admitted only when one downstream virtual channel (VC) has enough credits for the whole packet. The packet is then sent flit by flit with no interleaving, and a head arriving on the other input does not cut into it. The hop keeps one credit counter for each downstream VC. A taken flit is registered once and appears downstream on the next cycle.

Each source offers one flit at a time with a valid, a head flag and a 128-bit payload. The hop answers with a take strobe in the same cycle, and that strobe is the source's dequeue. Downstream buffers return credits one flit at a time, each tagged with its VC.

Top module: `subnet_hop`

## Requirements
- R1: After reset, `out_vld` is 0 and every downstream VC counter holds VC_DEPTH credits. With no credits returned, exactly NUM_VC*VC_DEPTH flits of 4-flit packets can be forwarded.
- R2: While no packet is open, a flit whose head flag is 0 is never taken on either input. It stays offered with its take strobe at 0.
- R3: A head flit of length L is taken only when at least one downstream VC has L or more credits. No VC ever has more than VC_DEPTH flits outstanding.
- R4: With the default selection variant, a packet is assigned the lowest-numbered VC that holds at least L credits. That VC number is shown on `out_vc` with the head flit.
- R5: After a head of length L is taken, the next L-1 takes come only from the same input, whenever it is valid. The other input is not taken during that time. Every flit of the packet leaves on the same `out_vc`.
- R6: At a packet boundary, when both inputs offer an admissible head, the input favoured by a one-bit pointer wins. After each grant the pointer moves to the losing input. After reset the pointer favours the network input.
- R7: A flit taken in cycle t appears on `out_vld`, `out_head` and `out_data` in cycle t+1 with its payload and head flag unchanged. A cycle with no take gives `out_vld` 0 in the next cycle.
- R8: A returned credit (`cr_vld`, `cr_vc`) adds one to that VC's counter. A credit return and a flit send on the same VC in the same cycle leave the counter unchanged.
- R9: The packet length in flits is carried in bits [2:0] of the head flit payload. The values used are 1 and 4.
- R10: At most one input is taken in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| net_vld | input | 1 | Upstream subnet channel offers a flit |
| net_head | input | 1 | Offered upstream flit is a packet head |
| net_data | input | FLIT_W | Upstream flit payload; length in bits [2:0] of a head |
| net_take | output | 1 | Upstream flit is consumed this cycle |
| loc_vld | input | 1 | Local injection port offers a flit |
| loc_head | input | 1 | Offered local flit is a packet head |
| loc_data | input | FLIT_W | Local flit payload; length in bits [2:0] of a head |
| loc_take | output | 1 | Local flit is consumed this cycle |
| out_vld | output | 1 | Downstream flit valid |
| out_head | output | 1 | Downstream flit is a head |
| out_data | output | FLIT_W | Downstream flit payload |
| out_vc | output | VCW | Downstream VC the flit is written into |
| cr_vld | input | 1 | One credit returned by the downstream buffer |
| cr_vc | input | VCW | VC the returned credit belongs to |

## Verification
Two things can happen in the same cycle: a credit returned from downstream and a flit sent into that same VC. Both change one counter at once. The bench returns credits at random from VCs that hold delivered but uncredited flits while traffic keeps flowing, so this overlap happens many times. The bench's own credit ledger then decides which heads are admissible and which VC each one should get, and every take strobe and every `out_vc` is compared against it. The checker separately tracks outstanding flits per VC and requires that none ever exceeds the buffer depth.

// File: rtl/subnet_hop_pkg.sv
package subnet_hop_pkg;

   typedef enum logic {
      SRC_NET = 1'b0,
      SRC_LOC = 1'b1
   } hop_src_e;

   function automatic hop_src_e other_src(input hop_src_e s);
      return (s == SRC_NET) ? SRC_LOC : SRC_NET;
   endfunction

endpackage

// File: rtl/subnet_hop_credits.sv
module subnet_hop_credits #(
   parameter int NUM_VC   = 2,
   parameter int VC_DEPTH = 4,
   localparam int VCW     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW      = $clog2(VC_DEPTH + 1)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         dec_vld,
   input  logic [VCW-1:0]               dec_vc,
   input  logic                         inc_vld,
   input  logic [VCW-1:0]               inc_vc,
   output logic [NUM_VC-1:0][CW-1:0]    cred
);

   for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
      logic hit_dec;
      logic hit_inc;

      assign hit_dec = dec_vld && (dec_vc == VCW'(v));
      assign hit_inc = inc_vld && (inc_vc == VCW'(v));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cred[v] <= CW'(VC_DEPTH);
         end else begin
            case ({hit_inc, hit_dec})
               2'b10:   cred[v] <= cred[v] + CW'(1);
               2'b01:   cred[v] <= cred[v] - CW'(1);
               default: cred[v] <= cred[v];
            endcase
         end
      end
   end

endmodule

// File: rtl/subnet_hop_vc_pick.sv
module subnet_hop_vc_pick #(
   parameter int NUM_VC    = 2,
   parameter int VC_DEPTH  = 4,
   parameter int MAX_LEN   = 4,
   parameter bit PICK_MOST = 1'b0,
   localparam int VCW      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW       = $clog2(VC_DEPTH + 1),
   localparam int LEN_W    = $clog2(MAX_LEN + 1),
   localparam int KW       = (CW > LEN_W) ? CW : LEN_W
) (
   input  logic [NUM_VC-1:0][CW-1:0] cred,
   input  logic [LEN_W-1:0]          need,
   output logic                      found,
   output logic [VCW-1:0]            vc
);

   logic [NUM_VC-1:0] fits;

   for (genvar v = 0; v < NUM_VC; v++) begin : g_fit
      assign fits[v] = KW'(cred[v]) >= KW'(need);
   end

   if (PICK_MOST) begin : g_most
      always_comb begin
         logic [CW-1:0] best;
         found = 1'b0;
         vc    = '0;
         best  = '0;
         for (int v = 0; v < NUM_VC; v++) begin
            if (fits[v] && (!found || cred[v] > best)) begin
               found = 1'b1;
               vc    = VCW'(v);
               best  = cred[v];
            end
         end
      end
   end else begin : g_lowest
      always_comb begin
         found = 1'b0;
         vc    = '0;
         for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (fits[v]) begin
               found = 1'b1;
               vc    = VCW'(v);
            end
         end
      end
   end

endmodule

// File: rtl/subnet_hop_arb.sv
module subnet_hop_arb
   import subnet_hop_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic open_pkt,
   input  logic elig_net,
   input  logic elig_loc,
   output logic gnt_net,
   output logic gnt_loc
);

   hop_src_e favour_q;

   assign gnt_net = !open_pkt && elig_net && (!elig_loc || favour_q == SRC_NET);
   assign gnt_loc = !open_pkt && elig_loc && (!elig_net || favour_q == SRC_LOC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         favour_q <= SRC_NET;
      end else if (gnt_net) begin
         favour_q <= other_src(SRC_NET);
      end else if (gnt_loc) begin
         favour_q <= other_src(SRC_LOC);
      end
   end

endmodule

// File: rtl/subnet_hop.sv
module subnet_hop
   import subnet_hop_pkg::*;
#(
   parameter int FLIT_W    = 128,
   parameter int NUM_VC    = 2,
   parameter int VC_DEPTH  = 4,
   parameter int MAX_LEN   = 4,
   parameter bit PICK_MOST = 1'b0,
   localparam int VCW      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW       = $clog2(VC_DEPTH + 1),
   localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              net_vld,
   input  logic              net_head,
   input  logic [FLIT_W-1:0] net_data,
   output logic              net_take,
   input  logic              loc_vld,
   input  logic              loc_head,
   input  logic [FLIT_W-1:0] loc_data,
   output logic              loc_take,
   output logic              out_vld,
   output logic              out_head,
   output logic [FLIT_W-1:0] out_data,
   output logic [VCW-1:0]    out_vc,
   input  logic              cr_vld,
   input  logic [VCW-1:0]    cr_vc
);

   if (VC_DEPTH < MAX_LEN) begin : g_bad_depth
      $error("subnet_hop: a VC buffer must hold a maximum-length packet");
   end
   if (FLIT_W <= LEN_W) begin : g_bad_width
      $error("subnet_hop: flit too narrow for the length field");
   end
   if (NUM_VC < 1) begin : g_bad_vc
      $error("subnet_hop: at least one downstream VC is required");
   end

   logic [NUM_VC-1:0][CW-1:0] cred;
   logic                      open_q;
   hop_src_e                  owner_q;
   logic [LEN_W-1:0]          rem_q;
   logic [VCW-1:0]            vc_q;

   logic [LEN_W-1:0] len_net, len_loc;
   logic             fit_net, fit_loc;
   logic [VCW-1:0]   vc_net,  vc_loc;
   logic             gnt_net, gnt_loc;
   logic             fire;
   hop_src_e         sel;
   logic [VCW-1:0]   snd_vc;
   logic [LEN_W-1:0] snd_len;

   // length field of a head flit; a zero count is read as one flit
   function automatic logic [LEN_W-1:0] head_len(input logic [FLIT_W-1:0] d);
      logic [LEN_W-1:0] l;
      l = d[LEN_W-1:0];
      return (l == '0) ? LEN_W'(1) : l;
   endfunction

   assign len_net = head_len(net_data);
   assign len_loc = head_len(loc_data);

   subnet_hop_vc_pick #(
      .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH), .MAX_LEN(MAX_LEN), .PICK_MOST(PICK_MOST)
   ) u_pick_net (
      .cred(cred), .need(len_net), .found(fit_net), .vc(vc_net)
   );

   subnet_hop_vc_pick #(
      .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH), .MAX_LEN(MAX_LEN), .PICK_MOST(PICK_MOST)
   ) u_pick_loc (
      .cred(cred), .need(len_loc), .found(fit_loc), .vc(vc_loc)
   );

   subnet_hop_arb u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_pkt (open_q),
      .elig_net (net_vld && net_head && fit_net),
      .elig_loc (loc_vld && loc_head && fit_loc),
      .gnt_net  (gnt_net),
      .gnt_loc  (gnt_loc)
   );

   // input selection: an open packet holds the mux until its last flit
   always_comb begin
      if (open_q) begin
         net_take = (owner_q == SRC_NET) && net_vld;
         loc_take = (owner_q == SRC_LOC) && loc_vld;
         sel      = owner_q;
         snd_vc   = vc_q;
         snd_len  = rem_q;
      end else begin
         net_take = gnt_net;
         loc_take = gnt_loc;
         sel      = gnt_loc ? SRC_LOC : SRC_NET;
         snd_vc   = gnt_loc ? vc_loc  : vc_net;
         snd_len  = gnt_loc ? len_loc : len_net;
      end
   end

   assign fire = net_take || loc_take;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_q  <= 1'b0;
         owner_q <= SRC_NET;
         rem_q   <= '0;
         vc_q    <= '0;
      end else if (fire) begin
         if (!open_q) begin
            open_q  <= snd_len > LEN_W'(1);
            owner_q <= sel;
            rem_q   <= snd_len - LEN_W'(1);
            vc_q    <= snd_vc;
         end else begin
            rem_q <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) begin
               open_q <= 1'b0;
            end
         end
      end
   end

   subnet_hop_credits #(
      .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH)
   ) u_credits (
      .clk     (clk),
      .rst_n   (rst_n),
      .dec_vld (fire),
      .dec_vc  (snd_vc),
      .inc_vld (cr_vld),
      .inc_vc  (cr_vc),
      .cred    (cred)
   );

   // single output register: the whole hop traversal
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_head <= 1'b0;
         out_data <= '0;
         out_vc   <= '0;
      end else begin
         out_vld <= fire;
         if (fire) begin
            out_head <= (sel == SRC_LOC) ? loc_head : net_head;
            out_data <= (sel == SRC_LOC) ? loc_data : net_data;
            out_vc   <= snd_vc;
         end
      end
   end

endmodule

// File: rtl/subnet_hop_chk.sv
module subnet_hop_chk #(
   parameter int FLIT_W    = 128,
   parameter int NUM_VC    = 2,
   parameter int VC_DEPTH  = 4,
   parameter int MAX_LEN   = 4,
   parameter bit PICK_MOST = 1'b0,
   localparam int VCW      = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
   localparam int CW       = $clog2(VC_DEPTH + 1),
   localparam int LEN_W    = $clog2(MAX_LEN + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              net_vld,
   input logic              net_head,
   input logic [FLIT_W-1:0] net_data,
   input logic              net_take,
   input logic              loc_vld,
   input logic              loc_head,
   input logic [FLIT_W-1:0] loc_data,
   input logic              loc_take,
   input logic              out_vld,
   input logic              out_head,
   input logic [FLIT_W-1:0] out_data,
   input logic [VCW-1:0]    out_vc,
   input logic              cr_vld,
   input logic [VCW-1:0]    cr_vc
);

   logic             any_take;
   logic [LEN_W-1:0] tlen;
   logic             pkt_open_q;
   logic             pkt_loc_q;
   logic [LEN_W-1:0] pkt_rem_q;
   logic [VCW-1:0]   last_vc_q;

   assign any_take = net_take || loc_take;
   assign tlen     = loc_take ? loc_data[LEN_W-1:0] : net_data[LEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pkt_open_q <= 1'b0;
         pkt_loc_q  <= 1'b0;
         pkt_rem_q  <= '0;
         last_vc_q  <= '0;
      end else begin
         if (any_take) begin
            if (!pkt_open_q) begin
               if (tlen > LEN_W'(1)) begin
                  pkt_open_q <= 1'b1;
                  pkt_rem_q  <= tlen - LEN_W'(1);
                  pkt_loc_q  <= loc_take;
               end
            end else begin
               pkt_rem_q <= pkt_rem_q - LEN_W'(1);
               if (pkt_rem_q == LEN_W'(1)) pkt_open_q <= 1'b0;
            end
         end
         if (out_vld) last_vc_q <= out_vc;
      end
   end

   // outstanding flits per downstream VC, seen at the ports
   for (genvar v = 0; v < NUM_VC; v++) begin : g_outs
      logic [CW:0] outs_q;
      logic        snd, ret;
      assign snd = out_vld && (out_vc == VCW'(v));
      assign ret = cr_vld && (cr_vc == VCW'(v));
      always_ff @(posedge clk) begin
         if (!rst_n) outs_q <= '0;
         else if (snd && !ret) outs_q <= outs_q + 1'b1;
         else if (ret && !snd) outs_q <= outs_q - 1'b1;
      end
      p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
         outs_q <= (CW+1)'(VC_DEPTH));
   end

   p_one_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({net_take, loc_take}));

   p_idle_head_net_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_open_q && net_take) |-> net_head);

   p_idle_head_loc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!pkt_open_q && loc_take) |-> loc_head);

   p_atomic_net_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_open_q && !pkt_loc_q) |-> !loc_take);

   p_atomic_loc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_open_q && pkt_loc_q) |-> !net_take);

   p_vc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && !out_head) |-> (out_vc == last_vc_q));

   p_trav_net_r7: assert property (@(posedge clk) disable iff (!rst_n)
      net_take |=> (out_vld && out_data == $past(net_data) && out_head == $past(net_head)));

   p_trav_loc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      loc_take |=> (out_vld && out_data == $past(loc_data) && out_head == $past(loc_head)));

   p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_take |=> !out_vld);

endmodule

bind subnet_hop subnet_hop_chk #(
   .FLIT_W(FLIT_W), .NUM_VC(NUM_VC), .VC_DEPTH(VC_DEPTH),
   .MAX_LEN(MAX_LEN), .PICK_MOST(PICK_MOST)
) u_chk (.*);

// File: tb/test_subnet_hop.sv
`timescale 1ns/1ps
module test_subnet_hop;

   localparam int FW      = 128;
   localparam int NV      = 2;
   localparam int DEP     = 4;
   localparam int ML      = 4;
   localparam int VCW     = 1;
   localparam int CYC_LIM = 150000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          net_vld, net_head, net_take;
   logic [FW-1:0] net_data;
   logic          loc_vld, loc_head, loc_take;
   logic [FW-1:0] loc_data;
   logic          out_vld, out_head;
   logic [FW-1:0] out_data;
   logic [VCW-1:0] out_vc;
   logic          cr_vld;
   logic [VCW-1:0] cr_vc;

   always #2.5 clk = ~clk;

   subnet_hop #(.FLIT_W(FW), .NUM_VC(NV), .VC_DEPTH(DEP), .MAX_LEN(ML)) i_subnet_hop (
      .clk(clk), .rst_n(rst_n),
      .net_vld(net_vld), .net_head(net_head), .net_data(net_data), .net_take(net_take),
      .loc_vld(loc_vld), .loc_head(loc_head), .loc_data(loc_data), .loc_take(loc_take),
      .out_vld(out_vld), .out_head(out_head), .out_data(out_data), .out_vc(out_vc),
      .cr_vld(cr_vld), .cr_vc(cr_vc)
   );

   int n_chk = 0, n_fail = 0, cyc = 0, n_taken = 0;

   logic [FW-1:0] qn_d[$], ql_d[$];
   bit            qn_h[$], ql_h[$];

   // bench model of the hop
   int m_cred[NV];
   int dl[NV];
   bit m_lock, m_owner, m_rr;
   int m_rem, m_vc;
   bit            exp_vld, exp_head;
   logic [FW-1:0] exp_data;
   int            exp_vc;

   task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   function automatic logic [FW-1:0] rnd_flit();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   task automatic add_pkt(input bit to_loc, input int len);
      for (int i = 0; i < len; i++) begin
         logic [FW-1:0] d;
         d = rnd_flit();
         if (i == 0) d[2:0] = 3'(len);
         if (to_loc) begin ql_d.push_back(d); ql_h.push_back(i == 0); end
         else        begin qn_d.push_back(d); qn_h.push_back(i == 0); end
      end
   endtask

   function automatic int pick_vc(input int len);
      for (int v = 0; v < NV; v++) if (m_cred[v] >= len) return v;
      return -1;
   endfunction

   task automatic step(input int vld_pct, input bit cr_on);
      bit en_n, en_l, src;
      string tag;
      int ln, ll, len;
      @(negedge clk);
      cyc++;
      if (cyc > CYC_LIM) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired act=%0d exp=%0d", cyc, CYC_LIM);
         finish_run();
      end
      // R7: registered traversal of last cycle's take
      chk(out_vld === exp_vld, "R7 out_vld", FW'(out_vld), FW'(exp_vld));
      if (exp_vld) begin
         chk(out_data === exp_data, "R7 out_data", out_data, exp_data);
         chk(out_head === exp_head, "R7 out_head", FW'(out_head), FW'(exp_head));
         chk(int'(out_vc) == exp_vc, exp_head ? "R4 head vc" : "R5 body vc", FW'(out_vc), FW'(exp_vc));
      end
      if (out_vld) dl[out_vc]++;
      // drive inputs
      net_vld  = (qn_d.size() != 0) && ($urandom_range(99) < vld_pct);
      net_data = net_vld ? qn_d[0] : '0;
      net_head = net_vld ? qn_h[0] : 1'b0;
      loc_vld  = (ql_d.size() != 0) && ($urandom_range(99) < vld_pct);
      loc_data = loc_vld ? ql_d[0] : '0;
      loc_head = loc_vld ? ql_h[0] : 1'b0;
      cr_vld = 1'b0;
      cr_vc  = '0;
      if (cr_on && $urandom_range(3) != 0) begin
         int v0;
         v0 = $urandom_range(NV - 1);
         for (int k = 0; k < NV; k++) begin
            int v;
            v = (v0 + k) % NV;
            if (!cr_vld && dl[v] > 0) begin
               cr_vld = 1'b1;
               cr_vc  = VCW'(v);
               dl[v]--;
            end
         end
      end
      #1;
      // model of expected takes
      ln = net_data[2:0];
      ll = loc_data[2:0];
      if (m_lock) begin
         en_n = !m_owner && net_vld;
         en_l =  m_owner && loc_vld;
         tag  = "R5 open packet";
      end else begin
         bit fn, fl;
         fn = net_vld && net_head && pick_vc(ln) >= 0;
         fl = loc_vld && loc_head && pick_vc(ll) >= 0;
         if (fn && fl) begin
            en_n = !m_rr; en_l = m_rr; tag = "R6 contention";
         end else begin
            en_n = fn; en_l = fl;
            tag = ((net_vld && !net_head) || (loc_vld && !loc_head)) ? "R2 idle body" : "R3 admission";
         end
      end
      chk(net_take === en_n, {tag, " net_take"}, FW'(net_take), FW'(en_n));
      chk(loc_take === en_l, {tag, " loc_take"}, FW'(loc_take), FW'(en_l));
      chk(!(net_take && loc_take), "R10 single take", FW'({net_take, loc_take}), 0);
      // advance with the design's actual takes
      exp_vld = net_take || loc_take;
      if (exp_vld) begin
         src      = loc_take;
         exp_data = src ? loc_data : net_data;
         exp_head = src ? loc_head : net_head;
         if (!m_lock) begin
            len = src ? ll : ln;
            m_vc = pick_vc(len);
            if (m_vc < 0) m_vc = 0;
            m_rem = len - 1;
            m_lock = (len > 1);
            m_owner = src;
            m_rr = !src;
         end else begin
            m_rem--;
            if (m_rem == 0) m_lock = 1'b0;
         end
         exp_vc = m_vc;
         m_cred[m_vc]--;
         n_taken++;
         if (src) begin void'(ql_d.pop_front()); void'(ql_h.pop_front()); end
         else     begin void'(qn_d.pop_front()); void'(qn_h.pop_front()); end
      end
      // R8: a return adds one; send and return together cancel
      if (cr_vld) m_cred[cr_vc]++;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0;
      net_vld = 0; net_head = 0; net_data = '0;
      loc_vld = 0; loc_head = 0; loc_data = '0;
      cr_vld = 0; cr_vc = '0;
      for (int v = 0; v < NV; v++) begin m_cred[v] = DEP; dl[v] = 0; end
      m_lock = 0; m_owner = 0; m_rr = 0; m_rem = 0; m_vc = 0;
      exp_vld = 0; exp_head = 0; exp_data = '0; exp_vc = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(out_vld === 1'b0, "R1 out_vld after reset", FW'(out_vld), 0);
      chk(net_take === 1'b0 && loc_take === 1'b0, "R1 no take when idle", FW'({net_take, loc_take}), 0);

      // R1/R3: no credit returns, only NV*DEP flits may pass
      for (int i = 0; i < 3; i++) begin add_pkt(0, 4); add_pkt(1, 4); end
      repeat (40) step(100, 0);
      chk(n_taken == NV * DEP, "R1 R3 flits passed without credits", FW'(n_taken), FW'(NV * DEP));
      repeat (80) step(100, 1);

      // R2: a body flit offered on an idle port is never taken
      while (qn_d.size() != 0 || ql_d.size() != 0 || m_lock) step(100, 1);
      ql_d.push_back(rnd_flit() | FW'(1));
      ql_h.push_back(1'b0);
      for (int i = 0; i < 5; i++) begin
         step(100, 1);
         chk(loc_take === 1'b0, "R2 body flit on idle port", FW'(loc_take), 0);
      end
      void'(ql_d.pop_front()); void'(ql_h.pop_front());

      // R6: single-flit contention alternates between the inputs
      repeat (8) step(100, 1);
      for (int i = 0; i < 6; i++) begin add_pkt(0, 1); add_pkt(1, 1); end
      repeat (60) step(100, 1);

      // random traffic; credit returns and sends overlap (R8, R9)
      for (int c = 0; c < 3000; c++) begin
         if (qn_d.size() < 12 && $urandom_range(3) == 0) add_pkt(0, $urandom_range(1) ? 4 : 1);
         if (ql_d.size() < 12 && $urandom_range(3) == 0) add_pkt(1, $urandom_range(1) ? 4 : 1);
         step(75, 1);
      end

      // drain
      while (qn_d.size() != 0 || ql_d.size() != 0 || m_lock) step(100, 1);
      repeat (40) step(100, 1);
      for (int v = 0; v < NV; v++)
         chk(m_cred[v] == DEP, "R8 ledger back to full", FW'(m_cred[v]), FW'(DEP));
      finish_run();
   end

endmodule